// File: doc/BRIEF.md
# Ring-Sequenced Operand/Address Unit

This block is a small function-unit sequencer that walks each operation through three steps without any request/acknowledge exchange between them. A circulating token in a ring counter marks the active step. The ring moves only in cycles where the enable input is high, so the whole unit behaves as if it sat on a gated clock. In the read step the unit places its two source register indices on a shared register-file trunk. The register file is a fully synchronous RAM, so the operand values come back on the trunk data buses in the next enabled cycle. In the sum step the adder output is registered. In the final step the unit either offers the result for register write-back or flags an outstanding memory command.

A start pulse that the unit accepts puts a token into the read position. An opcode bit picks between the two kinds of operation. An arithmetic operation adds the two operands and ends with a write-back strobe. A memory operation adds the first operand to an immediate and ends with a command-pending strobe. When idle, the trunk index outputs and the result outputs are all zero, so several units can share the trunk through a plain OR. A parameter selects one of two variants. The single-token variant accepts a new operation only when the ring is idle. The pipelined variant accepts one operation in every enabled cycle and carries up to three operations at once as a multi-hot ring pattern.

Top module: `rsq_addr_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, go_read, go_sum, go_write and cmd_pending are low, and trk_ra, trk_rb, res_o and wr_idx are zero.
- R2: When start is high and accepted in an enabled cycle, go_read is high in the next cycle and trk_ra/trk_rb carry rs1_idx/rs2_idx. trk_ra/trk_rb are zero in every cycle in which go_read is low.
- R3: go_sum is high in the first cycle after an enabled go_read cycle, for the same operation.
- R4: The result registered in the sum step is trk_da + trk_db when op_mem = 0, and trk_da + imm when op_mem = 1, modulo 2^DW. trk_da/trk_db are the values on the trunk in the sum cycle.
- R5: In the first cycle after an enabled go_sum cycle, go_write is high if op_mem was 0 and cmd_pending is high if op_mem was 1. That cycle shows res_o = result and wr_idx = dst_idx. Outside the final step both strobes are low and res_o and wr_idx are zero.
- R6: In a cycle with en low, no start is accepted and every output keeps its value in the next cycle.
- R7: With PIPELINED = 0, start is ignored while any operation is in the read, sum or final step, so at most one of the phase outputs is high at a time.
- R8: With PIPELINED = 1, start is accepted in every enabled cycle. Up to three operations are in flight, each in its own step with its own indices and result.
- R9: With PIPELINED = 0, the ring returns to idle after an enabled final-step cycle, and a start in that next enabled cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable (gated-clock qualifier) |
| start | input | 1 | Request to inject a new operation |
| op_mem | input | 1 | 1 = memory address, 0 = add with write-back |
| rs1_idx | input | AW | First source register index |
| rs2_idx | input | AW | Second source register index |
| dst_idx | input | AW | Destination register index |
| imm | input | DW | Immediate offset for memory operations |
| trk_da | input | DW | Trunk data for first source |
| trk_db | input | DW | Trunk data for second source |
| go_read | output | 1 | Read step active |
| go_sum | output | 1 | Sum step active |
| go_write | output | 1 | Final step, register write-back |
| cmd_pending | output | 1 | Final step, memory command outstanding |
| trk_ra | output | AW | First source index on trunk, zero when not reading |
| trk_rb | output | AW | Second source index on trunk, zero when not reading |
| res_o | output | DW | Result, zero outside final step |
| wr_idx | output | AW | Destination index, zero outside final step |

## Verification
The bench holds the enable low in each of the three steps in turn. A unit that lets its ring or its sum register move while disabled would show a phase or result one cycle early, or would capture stale trunk data. Starts are issued back to back, including in the final-step cycle. The single-token variant must drop the ones that arrive while busy and take the one that arrives right after the final step. A unit that checks idleness one cycle late would lose that operation or collide two tokens. The pipelined variant must show three separate operations in flight. Memory operations with immediates near 2^DW and random register values exercise carry wrap, and they catch a swapped add/address select as a wrong result or a wrong strobe.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // positions of the ring counter
  localparam int RING_LEN = 4;
  localparam int P_IDLE   = 0;
  localparam int P_RD     = 1;
  localparam int P_SM     = 2;
  localparam int P_FN     = 3;
  // number of operation-carrying stages
  localparam int N_STG    = RING_LEN - 1;
endpackage

// File: rtl/rsq_ring.sv
module rsq_ring
  import rsq_pkg::*;
#(
  parameter bit PIPELINED = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  output logic ph_rd,
  output logic ph_sm,
  output logic ph_fn,
  output logic accept
);
  logic [RING_LEN-1:0] ring_q, ring_d;
  logic can_take;

  generate
    if (PIPELINED) begin : g_multi
      assign can_take = 1'b1;
    end else begin : g_single
      assign can_take = ring_q[P_IDLE];
    end
  endgenerate

  assign accept = en & start & can_take;

  always_comb begin
    ring_d = ring_q;
    if (en) begin
      ring_d[P_RD]   = accept;
      ring_d[P_SM]   = ring_q[P_RD];
      ring_d[P_FN]   = ring_q[P_SM];
      ring_d[P_IDLE] = ~(accept | ring_q[P_RD] | ring_q[P_SM]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ring_q <= RING_LEN'(1) << P_IDLE;
    else     ring_q <= ring_d;
  end

  assign ph_rd = ring_q[P_RD];
  assign ph_sm = ring_q[P_SM];
  assign ph_fn = ring_q[P_FN];
endmodule

// File: rtl/rsq_stage_regs.sv
module rsq_stage_regs
  import rsq_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          accept,
  input  logic [AW-1:0] rs1_i,
  input  logic [AW-1:0] rs2_i,
  input  logic [AW-1:0] dst_i,
  input  logic          mem_i,
  input  logic [DW-1:0] imm_i,
  output logic [AW-1:0] rd_s1,
  output logic [AW-1:0] rd_s2,
  output logic          sm_mem,
  output logic [DW-1:0] sm_imm,
  output logic          fn_mem,
  output logic [AW-1:0] fn_dst
);
  typedef struct packed {
    logic          is_mem;
    logic [AW-1:0] dst;
    logic [DW-1:0] imm;
  } tag_t;

  tag_t          stg_q [N_STG];
  logic [AW-1:0] s1_q, s2_q;

  // source indices live only in the read stage
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (accept) begin
      s1_q <= rs1_i;
      s2_q <= rs2_i;
    end
  end

  // tag shift chain, moves on every enabled cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_STG; k++) stg_q[k] <= '0;
    end else if (en) begin
      if (accept) stg_q[0] <= '{is_mem: mem_i, dst: dst_i, imm: imm_i};
      for (int k = 1; k < N_STG; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign rd_s1  = s1_q;
  assign rd_s2  = s2_q;
  assign sm_mem = stg_q[1].is_mem;
  assign sm_imm = stg_q[1].imm;
  assign fn_mem = stg_q[N_STG-1].is_mem;
  assign fn_dst = stg_q[N_STG-1].dst;
endmodule

// File: rtl/rsq_sum.sv
module rsq_sum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          take,
  input  logic          is_mem,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] da,
  input  logic [DW-1:0] db,
  output logic [DW-1:0] res_q
);
  logic [DW-1:0] addend;
  logic [DW-1:0] sum;

  assign addend = is_mem ? imm : db;
  assign sum    = da + addend;

  always_ff @(posedge clk) begin
    if (rst)             res_q <= '0;
    else if (en && take) res_q <= sum;
  end
endmodule

// File: rtl/rsq_addr_unit.sv
module rsq_addr_unit
  import rsq_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 32,
  parameter bit PIPELINED = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic          op_mem,
  input  logic [AW-1:0] rs1_idx,
  input  logic [AW-1:0] rs2_idx,
  input  logic [AW-1:0] dst_idx,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] trk_da,
  input  logic [DW-1:0] trk_db,
  output logic          go_read,
  output logic          go_sum,
  output logic          go_write,
  output logic          cmd_pending,
  output logic [AW-1:0] trk_ra,
  output logic [AW-1:0] trk_rb,
  output logic [DW-1:0] res_o,
  output logic [AW-1:0] wr_idx
);
  logic          ph_rd, ph_sm, ph_fn, accept;
  logic [AW-1:0] rd_s1, rd_s2, fn_dst;
  logic          sm_mem, fn_mem;
  logic [DW-1:0] sm_imm, res_q;

  rsq_ring #(.PIPELINED(PIPELINED)) ring_i (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .ph_rd(ph_rd), .ph_sm(ph_sm), .ph_fn(ph_fn), .accept(accept)
  );

  rsq_stage_regs #(.AW(AW), .DW(DW)) stg_i (
    .clk(clk), .rst(rst), .en(en), .accept(accept),
    .rs1_i(rs1_idx), .rs2_i(rs2_idx), .dst_i(dst_idx),
    .mem_i(op_mem), .imm_i(imm),
    .rd_s1(rd_s1), .rd_s2(rd_s2),
    .sm_mem(sm_mem), .sm_imm(sm_imm),
    .fn_mem(fn_mem), .fn_dst(fn_dst)
  );

  rsq_sum #(.DW(DW)) sum_i (
    .clk(clk), .rst(rst), .en(en), .take(ph_sm),
    .is_mem(sm_mem), .imm(sm_imm), .da(trk_da), .db(trk_db),
    .res_q(res_q)
  );

  // trunk and result buses are zero when inactive for OR-sharing
  assign go_read     = ph_rd;
  assign go_sum      = ph_sm;
  assign go_write    = ph_fn & ~fn_mem;
  assign cmd_pending = ph_fn &  fn_mem;
  assign trk_ra      = ph_rd ? rd_s1 : '0;
  assign trk_rb      = ph_rd ? rd_s2 : '0;
  assign res_o       = ph_fn ? res_q : '0;
  assign wr_idx      = ph_fn ? fn_dst : '0;
endmodule

// File: rtl/rsq_addr_unit_chk.sv
module rsq_addr_unit_chk #(
  parameter int AW        = 5,
  parameter int DW        = 32,
  parameter bit PIPELINED = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          start,
  input logic          go_read,
  input logic          go_sum,
  input logic          go_write,
  input logic          cmd_pending,
  input logic [AW-1:0] trk_ra,
  input logic [AW-1:0] trk_rb,
  input logic [DW-1:0] res_o,
  input logic [AW-1:0] wr_idx
);
  logic fin;
  assign fin = go_write | cmd_pending;

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!go_read && !go_sum && !fin && res_o == '0 && wr_idx == '0));

  a_r2_trunk_zero: assert property (@(posedge clk) disable iff (rst)
    !go_read |-> (trk_ra == '0 && trk_rb == '0));

  a_r3_sum_after_read: assert property (@(posedge clk) disable iff (rst)
    (en && go_read) |=> go_sum);

  a_r5_final_after_sum: assert property (@(posedge clk) disable iff (rst)
    (en && go_sum) |=> fin);

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(go_write && cmd_pending));

  a_r5_idle_result_zero: assert property (@(posedge clk) disable iff (rst)
    !fin |-> (res_o == '0 && wr_idx == '0));

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable({go_read, go_sum, go_write, cmd_pending, trk_ra, trk_rb, res_o, wr_idx}));

  a_r7_single_token: assert property (@(posedge clk) disable iff (rst)
    PIPELINED || $onehot0({go_read, go_sum, fin}));

  a_r8_take_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (PIPELINED && en && start) |=> go_read);

  a_r9_back_to_idle: assert property (@(posedge clk) disable iff (rst)
    (!PIPELINED && en && fin) |=> (!go_sum && !fin));
endmodule

bind rsq_addr_unit rsq_addr_unit_chk #(.AW(AW), .DW(DW), .PIPELINED(PIPELINED)) chk_i (
  .clk(clk), .rst(rst), .en(en), .start(start),
  .go_read(go_read), .go_sum(go_sum), .go_write(go_write), .cmd_pending(cmd_pending),
  .trk_ra(trk_ra), .trk_rb(trk_rb), .res_o(res_o), .wr_idx(wr_idx)
);

// File: tb/rsq_addr_unit_tb_top.sv
module rsq_addr_unit_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic rst = 1'b1, en = 1'b0, start = 1'b0, op_mem = 1'b0;
  logic [AW-1:0] rs1 = '0, rs2 = '0, dst = '0;
  logic [DW-1:0] imm = '0;

  // per-variant trunk data and outputs: index 0 single-token, 1 pipelined
  logic [DW-1:0] da [2], db [2];
  logic [1:0] o_rd, o_sm, o_wr, o_cmd;
  logic [AW-1:0] o_ra [2], o_rb [2], o_wi [2];
  logic [DW-1:0] o_res [2];

  rsq_addr_unit #(.AW(AW), .DW(DW), .PIPELINED(1'b0)) dut_i (
    .clk(clk), .rst(rst), .en(en), .start(start), .op_mem(op_mem),
    .rs1_idx(rs1), .rs2_idx(rs2), .dst_idx(dst), .imm(imm),
    .trk_da(da[0]), .trk_db(db[0]),
    .go_read(o_rd[0]), .go_sum(o_sm[0]), .go_write(o_wr[0]), .cmd_pending(o_cmd[0]),
    .trk_ra(o_ra[0]), .trk_rb(o_rb[0]), .res_o(o_res[0]), .wr_idx(o_wi[0])
  );

  rsq_addr_unit #(.AW(AW), .DW(DW), .PIPELINED(1'b1)) dut_p_i (
    .clk(clk), .rst(rst), .en(en), .start(start), .op_mem(op_mem),
    .rs1_idx(rs1), .rs2_idx(rs2), .dst_idx(dst), .imm(imm),
    .trk_da(da[1]), .trk_db(db[1]),
    .go_read(o_rd[1]), .go_sum(o_sm[1]), .go_write(o_wr[1]), .cmd_pending(o_cmd[1]),
    .trk_ra(o_ra[1]), .trk_rb(o_rb[1]), .res_o(o_res[1]), .wr_idx(o_wi[1])
  );

  int checks = 0, bad = 0, cyc = 0;
  bit done = 0, armed = 0;
  string focus = "R1";

  function automatic logic [DW-1:0] regval(input logic [AW-1:0] i);
    if (i == '0) return '0;
    return (DW'(i) * 32'h9E37_79B9) ^ 32'hF00F_0FF0;
  endfunction

  // register file model: synchronous, same enable as the unit
  logic [AW-1:0] ra_s [2], rb_s [2];
  always @(negedge clk) for (int v = 0; v < 2; v++) begin ra_s[v] = o_ra[v]; rb_s[v] = o_rb[v]; end
  always @(posedge clk) for (int v = 0; v < 2; v++)
    if (en) begin da[v] <= regval(ra_s[v]); db[v] <= regval(rb_s[v]); end

  // behavioural reference: ops keyed by age in enabled cycles
  bit m_r [2], m_s [2], m_f [2];
  logic [AW-1:0] r1 [2], r2 [2], rdst [2], s1 [2], s2 [2], sdst [2], fdst [2];
  bit rm [2], sm [2], fm [2];
  logic [DW-1:0] rimm [2], simm [2], fres [2];

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (rst) begin
        m_r[v] = 0; m_s[v] = 0; m_f[v] = 0;
      end else if (en) begin
        bit idle;
        idle = !(m_r[v] || m_s[v] || m_f[v]);
        m_f[v] = m_s[v]; fm[v] = sm[v]; fdst[v] = sdst[v];
        fres[v] = sm[v] ? regval(s1[v]) + simm[v] : regval(s1[v]) + regval(s2[v]);
        m_s[v] = m_r[v]; sm[v] = rm[v]; sdst[v] = rdst[v]; s1[v] = r1[v]; s2[v] = r2[v]; simm[v] = rimm[v];
        m_r[v] = start && (v == 1 || idle);
        rm[v] = op_mem; rdst[v] = dst; r1[v] = rs1; r2[v] = rs2; rimm[v] = imm;
      end
    end
    cyc++;
    if (cyc >= 1) armed = 1;
  end

  task automatic cmp(input int v, input string sig, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s v%0d %s (%s) act=%h exp=%h cyc=%0d", req, v, sig, focus, act, exp, cyc);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (armed && !done) begin
    for (int v = 0; v < 2; v++) begin
      string rq_r, rq_s;
      rq_r = rst ? "R1" : "R2";
      rq_s = rst ? "R1" : "R3";
      cmp(v, "go_read", rq_r, DW'(o_rd[v]), DW'(m_r[v]));
      cmp(v, "trk_ra", rq_r, DW'(o_ra[v]), m_r[v] ? DW'(r1[v]) : '0);
      cmp(v, "trk_rb", rq_r, DW'(o_rb[v]), m_r[v] ? DW'(r2[v]) : '0);
      cmp(v, "go_sum", rq_s, DW'(o_sm[v]), DW'(m_s[v]));
      cmp(v, "go_write", "R5", DW'(o_wr[v]), DW'(m_f[v] && !fm[v]));
      cmp(v, "cmd_pending", "R5", DW'(o_cmd[v]), DW'(m_f[v] && fm[v]));
      cmp(v, "res_o", "R4", o_res[v], m_f[v] ? fres[v] : '0);
      cmp(v, "wr_idx", "R5", DW'(o_wi[v]), m_f[v] ? DW'(fdst[v]) : '0);
    end
  end

  task automatic drive(input bit e, input bit s, input bit m, input int a, input int b, input int d, input logic [DW-1:0] k);
    en = e; start = s; op_mem = m; rs1 = AW'(a); rs2 = AW'(b); dst = AW'(d); imm = k;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    focus = "R1";                                   // R1: first cycle after reset
    drive(1, 0, 0, 0, 0, 0, '0);
    focus = "R2 R3 R4 R5 add";
    drive(1, 1, 0, 3, 9, 4, '0);
    repeat (5) drive(1, 0, 0, 0, 0, 0, '0);
    focus = "R4 R5 mem wrap";
    drive(1, 1, 1, 17, 2, 6, 32'hFFFF_FFF0);
    repeat (5) drive(1, 0, 0, 0, 0, 0, '0);
    focus = "R6 freeze";                            // en low in each step
    drive(1, 1, 0, 5, 7, 8, '0);
    drive(0, 1, 1, 1, 1, 1, '0);
    drive(0, 0, 0, 0, 0, 0, '0);
    drive(1, 0, 0, 0, 0, 0, '0);
    drive(0, 1, 0, 2, 2, 2, '0);
    drive(1, 0, 0, 0, 0, 0, '0);
    drive(0, 0, 0, 0, 0, 0, '0);
    drive(0, 0, 0, 0, 0, 0, '0);
    repeat (4) drive(1, 0, 0, 0, 0, 0, '0);
    focus = "R7 R8 R9 back-to-back";
    for (int i = 0; i < 9; i++) drive(1, 1, i[0], i + 1, 30 - i, i + 10, DW'(i * 1000));
    repeat (5) drive(1, 0, 0, 0, 0, 0, '0);
    focus = "R4 R6 R7 R8 random";
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 4) != 0, ($urandom % 5) < 2, $urandom % 2,
            int'($urandom % 32), int'($urandom % 32), int'($urandom % 32), $urandom);
    repeat (6) drive(1, 0, 0, 0, 0, 0, '0);
    finish_run();
  end

  initial begin
    #(CLK_NS * 50000);
    checks++; bad++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    finish_run();
  end
endmodule